// File: doc/BRIEF.md
# Oscillation Wait Interval Timer

This block is a free-running up-counter clocked by the main oscillator. It paces the wait for the oscillator to settle and serves as a coarse interval timer. Software picks one of three counter bits as the interval source through a 2-bit select field. Each falling edge of that bit sets a sticky flag. The interrupt line is high while the flag and its enable bit are both set.

A single 16-bit control word is read and written through a plain port. Writing 0 to the flag clears it, and writing 1 leaves it alone. Writing 0 to the clear bit zeroes the counter at that clock edge. While a read-modify-write read is in progress, the flag position reads as 1, so the write-back that follows cannot clear a flag by accident.

Top module: `osc_wait_timer`

## Requirements
- R1: `count` increases by one on every clock edge unless a clear is written. After its all-ones value it wraps to zero.
- R2: A write with bit 0 = 0 makes `count` read 0 after that clock edge. A write with bit 0 = 1 leaves counting undisturbed. Bit 0 always reads 1.
- R3: After reset, `count` is 0, `irq` is 0 and the control word reads 16'h0001 (flag, interrupt enable, general enable and select all 0).
- R4: Select field bits [2:1] choose the tap: 00 picks counter bit TAP_A, 01 picks TAP_B, and both 10 and 11 pick TAP_C.
- R5: When the selected tap goes from 1 to 0, the flag (bit 15) reads 1 one clock after `count` first shows the tap as 0, and not earlier.
- R6: A write with bit 15 = 0 clears the flag. A write with bit 15 = 1 leaves the flag unchanged.
- R7: When a tap falling edge and a flag-clearing write land on the same clock edge, the flag ends up 1.
- R8: While `rd_rmw` is 1, bit 15 of `rd_data` reads 1 whatever the flag holds.
- R9: `irq` equals the flag ANDed with the interrupt enable (bit 14).
- R10: Bit 14, bit 13 and the select field are read/write and update on every write. Bits 12 to 3 read as 0.
- R11: A change of the select field on its own does not set the flag, even when the old tap is 1 and the new tap is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset request |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word write data |
| rd_rmw | input | 1 | High during the read of a read-modify-write access |
| rd_data | output | 16 | Control word read data |
| irq | output | 1 | Interrupt request |
| count | output | CNT_W | Current counter value |

## Verification
The bench builds the timer with an 8-bit counter and taps at bits 2, 3 and 4. With these values each selectable falling edge comes within 32 cycles of a clear, and a full wrap of the counter comes within 256 cycles. Every select encoding, the exact cycle in which the flag sets, the collision between a set and a clear, and the spurious-edge case at a select change can then each be checked by walking `count` to a known value.

// File: rtl/osc_tmr_pkg.sv
package osc_tmr_pkg;

  localparam int REG_W    = 16;
  localparam int FLAG_BIT = 15;
  localparam int IE_BIT   = 14;
  localparam int EN_BIT   = 13;
  localparam int SEL_LO   = 1;
  localparam int SEL_HI   = 2;
  localparam int CLR_BIT  = 0;
  localparam int NUM_TAPS = 3;
  localparam int IDX_W    = $clog2(NUM_TAPS);

  typedef enum logic [1:0] {
    SEL_TAP_A     = 2'b00,
    SEL_TAP_B     = 2'b01,
    SEL_TAP_C     = 2'b10,
    SEL_TAP_C_ALT = 2'b11
  } tap_sel_e;

  // Map the software select code onto a tap index (R4)
  function automatic logic [IDX_W-1:0] tap_index(input tap_sel_e s);
    logic [IDX_W-1:0] idx;
    case (s)
      SEL_TAP_A: idx = IDX_W'(0);
      SEL_TAP_B: idx = IDX_W'(1);
      default:   idx = IDX_W'(2);
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/osc_tmr_counter.sv
module osc_tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_stb,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // Next state: a clear strobe overrides the increment
  always_comb begin
    if (clr_stb) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/osc_tmr_edge.sv
module osc_tmr_edge
  import osc_tmr_pkg::*;
#(
  parameter int N = NUM_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     taps,
  input  logic [IDX_W-1:0] sel_idx,
  output logic             fall
);

  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;
  logic [N-1:0] tap_fall;

  // Every tap keeps its own history, so switching the select
  // compares the new tap only with its own previous value.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_tap
      assign prev_d[g]   = taps[g];
      assign tap_fall[g] = prev_q[g] & ~taps[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    fall = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_idx == IDX_W'(i)) begin
        fall = tap_fall[i];
      end
    end
  end

endmodule

// File: rtl/osc_tmr_regs.sv
module osc_tmr_regs
  import osc_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_rmw,
  input  logic             hw_set,
  output logic [REG_W-1:0] rd_data,
  output logic             irq,
  output logic [IDX_W-1:0] sel_idx,
  output logic             clr_stb
);

  logic     flag_q, flag_d;
  logic     ie_q, ie_d;
  logic     en_q, en_d;
  tap_sel_e sel_q, sel_d;
  logic     cfg_load;
  logic     flag_wclr;
  logic     unused_wr_bits;

  assign unused_wr_bits = ^wr_data[EN_BIT-1:SEL_HI+1];

  assign cfg_load  = wr_en;
  assign flag_wclr = wr_en & ~wr_data[FLAG_BIT];
  assign clr_stb   = wr_en & ~wr_data[CLR_BIT];

  // Flag: a hardware set beats a software clear
  always_comb begin
    flag_d = flag_q;
    if (hw_set) begin
      flag_d = 1'b1;
    end else if (flag_wclr) begin
      flag_d = 1'b0;
    end
  end

  always_comb begin
    ie_d  = ie_q;
    en_d  = en_q;
    sel_d = sel_q;
    if (cfg_load) begin
      ie_d  = wr_data[IE_BIT];
      en_d  = wr_data[EN_BIT];
      sel_d = tap_sel_e'(wr_data[SEL_HI:SEL_LO]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      en_q   <= 1'b0;
      sel_q  <= SEL_TAP_A;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      en_q   <= en_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    rd_data                = '0;
    rd_data[FLAG_BIT]      = flag_q | rd_rmw;
    rd_data[IE_BIT]        = ie_q;
    rd_data[EN_BIT]        = en_q;
    rd_data[SEL_HI:SEL_LO] = sel_q;
    rd_data[CLR_BIT]       = 1'b1;
  end

  assign irq     = flag_q & ie_q;
  assign sel_idx = tap_index(sel_q);

endmodule

// File: rtl/osc_wait_timer.sv
module osc_wait_timer
  import osc_tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TAP_A = 19,
  parameter int TAP_B = 23,
  parameter int TAP_C = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             rd_rmw,
  output logic [15:0]      rd_data,
  output logic             irq,
  output logic [CNT_W-1:0] count
);

  localparam int TAP_POS [NUM_TAPS] = '{TAP_A, TAP_B, TAP_C};

  logic [NUM_TAPS-1:0] taps;
  logic [IDX_W-1:0]    sel_idx;
  logic                clr_stb;
  logic                tap_fall;

  genvar t;
  generate
    for (t = 0; t < NUM_TAPS; t++) begin : g_pick
      assign taps[t] = count[TAP_POS[t]];
    end
  endgenerate

  osc_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_stb (clr_stb),
    .count   (count)
  );

  osc_tmr_edge #(.N(NUM_TAPS)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .taps    (taps),
    .sel_idx (sel_idx),
    .fall    (tap_fall)
  );

  osc_tmr_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_rmw  (rd_rmw),
    .hw_set  (tap_fall),
    .rd_data (rd_data),
    .irq     (irq),
    .sel_idx (sel_idx),
    .clr_stb (clr_stb)
  );

endmodule

// File: rtl/osc_wait_timer_chk.sv
module osc_wait_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [15:0]      wr_data,
  input logic             rd_rmw,
  input logic [15:0]      rd_data,
  input logic             irq,
  input logic [CNT_W-1:0] count
);

  logic unused_chk_bits;
  assign unused_chk_bits = ^wr_data[14:1];

  assert_count_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_data[0]) |=> count == $past(count) + CNT_W'(1));

  assert_count_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> count == '0);

  assert_clr_reads_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0]);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] && !rd_rmw && !(wr_en && !wr_data[15])) |=> rd_data[15]);

  assert_rmw_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rmw |-> rd_data[15]);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rmw |-> irq == (rd_data[15] & rd_data[14]));

endmodule

bind osc_wait_timer osc_wait_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_rmw  (rd_rmw),
  .rd_data (rd_data),
  .irq     (irq),
  .count   (count)
);

// File: tb/tb_osc_wait_timer.sv
`timescale 1ns/100ps
module tb_osc_wait_timer;

  localparam int CW = 8;
  localparam int TA = 2;
  localparam int TB = 3;
  localparam int TC = 4;
  localparam int NV = 7;

  // {write data, expected read with bit 15 masked}
  localparam logic [31:0] VEC [NV] = '{
    {16'h8003, 16'h0003},
    {16'hA005, 16'h2005},
    {16'hA007, 16'h2007},
    {16'hC001, 16'h4001},
    {16'hE007, 16'h6007},
    {16'h9FF9, 16'h0001},
    {16'h8001, 16'h0001}
  };

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [15:0]   wr_data;
  logic          rd_rmw;
  logic [15:0]   rd_data;
  logic          irq;
  logic [CW-1:0] count;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  osc_wait_timer #(.CNT_W(CW), .TAP_A(TA), .TAP_B(TB), .TAP_C(TC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_rmw(rd_rmw), .rd_data(rd_data), .irq(irq), .count(count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 16'h8001;
  endtask

  task automatic wait_cnt(input logic [CW-1:0] v);
    for (int i = 0; i < 600; i++) begin
      if (count == v) return;
      @(negedge clk);
    end
    chk("wait_count", 32'(count), 32'(v));
  endtask

  // cfg with ie=1 and select s, flag written 1, clear bit 1
  function automatic logic [15:0] cfg(input logic ie, input logic [1:0] s);
    return 16'h8001 | (16'(ie) << 14) | (16'(s) << 1);
  endfunction

  initial begin
    #500000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c0;
    logic [CW-1:0] edge_cnt;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 16'h8001; rd_rmw = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 rd_data", 32'(rd_data), 32'h0001);
    chk("R3 irq", 32'(irq), 0);
    chk("R3 count", 32'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first inc", 32'(count), 1);
    repeat (5) @(negedge clk);
    chk("R1 six", 32'(count), 6);

    // Register table walk (R10, R2 no-clear)
    for (int i = 0; i < NV; i++) begin
      c0 = count;
      wr(VEC[i][31:16]);
      chk("R10 readback", 32'(rd_data & 16'h7FFF), 32'(VEC[i][15:0]));
      chk("R2 no clear", 32'(count), 32'(CW'(c0 + 1)));
    end

    // Wrap (R1)
    wait_cnt({CW{1'b1}});
    @(negedge clk);
    chk("R1 wrap", 32'(count), 0);

    // Clear strobe (R2)
    wr(16'h8000);
    chk("R2 clear", 32'(count), 0);
    @(negedge clk);
    chk("R2 resume", 32'(count), 1);

    // Flag timing for each select code (R4, R5, R9)
    for (int s = 0; s < 4; s++) begin
      int b;
      b = (s == 0) ? TA : (s == 1) ? TB : TC;
      edge_cnt = CW'(1 << (b + 1));
      wr(cfg(1'b1, 2'(s)));
      wr(cfg(1'b1, 2'(s)) & 16'hFFFE);
      @(negedge clk);
      wr(cfg(1'b1, 2'(s)) & 16'h7FFF);
      chk("R6 flag cleared", 32'(rd_data[15]), 0);
      chk("R9 irq low", 32'(irq), 0);
      wait_cnt(edge_cnt);
      chk("R5 not early", 32'(rd_data[15]), 0);
      @(negedge clk);
      chk("R4 R5 flag set", 32'(rd_data[15]), 1);
      chk("R9 irq high", 32'(irq), 1);
    end

    // Write 1 keeps the flag, ie=0 gates irq (R6, R9)
    wr(cfg(1'b1, 2'b00));
    chk("R6 write one keeps", 32'(rd_data[15]), 1);
    wr(cfg(1'b0, 2'b00));
    chk("R9 ie off", 32'(irq), 0);
    chk("R9 flag kept", 32'(rd_data[15]), 1);

    // Read-modify-write read (R8)
    wr(cfg(1'b0, 2'b00) & 16'h7FFF);
    chk("R8 flag zero", 32'(rd_data[15]), 0);
    rd_rmw = 1'b1;
    #0.5;
    chk("R8 rmw reads one", 32'(rd_data[15]), 1);
    rd_rmw = 1'b0;
    #0.5;
    chk("R8 back to zero", 32'(rd_data[15]), 0);

    // Set wins over clear (R7)
    wr(cfg(1'b1, 2'b00) & 16'hFFFE);
    @(negedge clk);
    wr(cfg(1'b1, 2'b00) & 16'h7FFF);
    wait_cnt(CW'(1 << (TA + 1)));
    wr(cfg(1'b1, 2'b00) & 16'h7FFF);
    chk("R7 set wins", 32'(rd_data[15]), 1);

    // Select change alone makes no edge (R11)
    wr(cfg(1'b0, 2'b00) & 16'hFFFE);
    @(negedge clk);
    wr(cfg(1'b0, 2'b00) & 16'h7FFF);
    wait_cnt(CW'(5));
    wr(cfg(1'b0, 2'b10));
    for (int k = 0; k < 3; k++) begin
      chk("R11 no spurious", 32'(rd_data[15]), 0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule